// File: doc/BRIEF.md
# SDHCI sub-word register access bridge

This block sits between a host that addresses an SD host-controller register window with 8-, 16- and 32-bit accesses at the usual SDHCI offsets and a register file that only accepts aligned 32-bit reads and writes. Narrow reads fetch the enclosing word and shift the addressed lane down. Narrow writes become a read of the enclosing word followed by a write of the merged word.

Four offsets get special treatment. The transfer-mode halfword is parked in an internal 32-bit holding register until the command halfword arrives, and then both go out as one word write. The clock-control halfword is translated in both directions between the SDHCI divisor layout and a backend field that holds a flat 10-bit divide ratio. Word reads of the capabilities and present-state registers can be altered by two configuration inputs.

The host raises `hostReq` and holds all request fields until it sees the one-cycle `hostReady` pulse. Read data is valid during that pulse. The backend side is a single-outstanding request/ready port.

Top module: `sdhci_lane_bridge`

## Requirements
- R1: A byte read (hostSize 0) returns, in bits 7..0, byte lane (addr mod 4) of the backend word at addr with its two low bits cleared; the upper bits are zero.
- R2: A byte write, or a halfword write (hostSize 1) to any offset other than 0x0C, 0x0E and 0x2C, reads the aligned backend word, replaces only the addressed lane starting at bit (addr mod 4)×8, and writes the whole word back; hostReady is not raised before that write completes.
- R3: A halfword write to offset 0x0C only updates bits 15..0 of the holding register and issues no backend access.
- R4: A halfword write to offset 0x0E loads bits 31..16 of the holding register and then issues exactly one backend write to address 0x0C carrying the whole holding register.
- R5: Halfword reads of 0x0C and 0x0E return the low and high halves of the holding register, without a backend access; the holding register is zero after reset.
- R6: A halfword write to 0x2C with v3Mode low takes the divisor from host bits 15..8, doubles it, and writes it into backend bits 15..6, with backend bits 31..16 preserved and bits 5..0 taken from the host.
- R7: With v3Mode high, host bits 7..6 become divisor bits 9..8 before doubling, and a doubled value above 1023 is written as 1023.
- R8: A halfword read of 0x2C halves backend bits 15..6, returns bits 7..0 of the result in bits 15..8 and, only with v3Mode high, bits 9..8 of the result in bits 7..6; bits 5..0 pass through and bits 31..16 are zero.
- R9: A word read of offset 0x40 clears bit 21 when disableHighSpeed is high and is unmodified otherwise.
- R10: A word read of offset 0x24 sets bit 16 when forceCardPresent is high and is unmodified otherwise.
- R11: A word write (hostSize 2) is one backend write of the host data with no backend read; other word reads return the backend word unchanged.
- R12: The backend request stays high with a stable address until beReady; hostReady is a single-cycle pulse, and no backend request is active while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 byte, 1 halfword, 2 word |
| hostAddr | input | ADDR_W | Byte offset in the SDHCI window |
| hostWdata | input | 32 | Write data, right-aligned |
| hostRdata | output | 32 | Read data, right-aligned, valid with hostReady |
| hostReady | output | 1 | One-cycle completion pulse |
| v3Mode | input | 1 | Use the 10-bit (version 3.0) divisor layout |
| disableHighSpeed | input | 1 | Hide high-speed support in capabilities reads |
| forceCardPresent | input | 1 | Report a card as present in state reads |
| beReq | output | 1 | Backend request |
| beWrite | output | 1 | Backend write when high |
| beAddr | output | ADDR_W | Word-aligned backend address |
| beWdata | output | 32 | Backend write data |
| beRdata | input | 32 | Backend read data, valid with beReady |
| beReady | input | 1 | Backend completion |

## Verification
A corrupted holding register shows up directly at the host port on the next halfword read of 0x0C or 0x0E. It also shows up at the backend on the next command write, which carries the stale half. A wrong lane shift or mask in the merge shows on the very next backend write as a changed neighbouring byte. Divisor errors show up in one access, through saturation at the v3 top value and through the odd backend value whose halving drops a bit. A misclassified request shows within a few cycles, as an unexpected backend read or write counted at the backend model, or as a missing one.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;
  localparam int DATA_W = 32;

  localparam int OFF_XFER = 'h0C;
  localparam int OFF_CMD  = 'h0E;
  localparam int OFF_STATE = 'h24;
  localparam int OFF_CLK  = 'h2C;
  localparam int OFF_CAPS = 'h40;

  localparam int BIT_CARD_IN = 16;
  localparam int BIT_HISPEED = 21;
  localparam int DIV_MAX     = 1023;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    OP_READ, OP_WORD_WR, OP_RMW, OP_XFER_WR, OP_HOLD_RD, OP_CMD_WR
  } opKind_t;

  typedef struct packed {
    logic latchReq;
    logic captureRd;
    logic holdLoWr;
    logic holdHiWr;
  } dpCtl_t;
endpackage

// File: rtl/lane_bridge_dp.sv
module lane_bridge_dp
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  opKind_t           kind,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              v3Mode,
  input  logic              disableHighSpeed,
  input  logic              forceCardPresent,
  input  logic [DATA_W-1:0] beRdata,
  output opKind_t           opNow,
  output logic [ADDR_W-1:0] beAddr,
  output logic [DATA_W-1:0] beWdata,
  output logic [DATA_W-1:0] hostRdata
);
  localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(OFF_XFER);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFF_STATE);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(OFF_CLK);
  localparam logic [ADDR_W-1:0] A_CAPS  = ADDR_W'(OFF_CAPS);

  logic [ADDR_W-1:0] rAddr;
  logic [1:0]        rSize;
  logic [DATA_W-1:0] rData;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] hold;

  // classify the incoming request
  always_comb begin
    logic inHalf;
    inHalf = (hostSize == SZ_HALF);
    if (hostWrite) begin
      if (hostSize[1])                    opNow = OP_WORD_WR;
      else if (inHalf && hostAddr == A_XFER) opNow = OP_XFER_WR;
      else if (inHalf && hostAddr == A_CMD)  opNow = OP_CMD_WR;
      else                                opNow = OP_RMW;
    end else begin
      if (inHalf && (hostAddr == A_XFER || hostAddr == A_CMD)) opNow = OP_HOLD_RD;
      else                                                    opNow = OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rAddr  <= '0;
      rSize  <= '0;
      rData  <= '0;
      rdWord <= '0;
      hold   <= '0;
    end else begin
      if (ctl.latchReq) begin
        rAddr <= hostAddr;
        rSize <= hostSize;
        rData <= hostWdata;
      end
      if (ctl.captureRd) rdWord <= beRdata;
      if (ctl.holdLoWr)  hold[15:0]  <= hostWdata[15:0];
      if (ctl.holdHiWr)  hold[31:16] <= hostWdata[15:0];
    end
  end

  logic [4:0]        shamt;
  logic [DATA_W-1:0] laneMask, laneData, merged, laneRd;
  logic              rHalf, rClk;
  logic [9:0]        divIn, divSat;
  logic [10:0]       divDbl;
  logic [8:0]        divHalf;
  logic [15:0]       clkRd;
  logic [DATA_W-1:0] wordRd;

  assign shamt = {rAddr[1:0], 3'b000};
  assign rHalf = (rSize == SZ_HALF);
  assign rClk  = rHalf && (rAddr == A_CLK);

  // lane insert for read-modify-write
  always_comb begin
    laneMask = (rSize == SZ_BYTE ? 32'h0000_00FF : 32'h0000_FFFF) << shamt;
    laneData = (rData & (rSize == SZ_BYTE ? 32'h0000_00FF : 32'h0000_FFFF)) << shamt;
    merged   = (rdWord & ~laneMask) | laneData;
  end

  // host divisor layout -> flat ratio field
  always_comb begin
    divIn  = {v3Mode ? rData[7:6] : 2'b00, rData[15:8]};
    divDbl = {divIn, 1'b0};
    divSat = (divDbl > 11'(DIV_MAX)) ? 10'(DIV_MAX) : divDbl[9:0];
  end

  // flat ratio field -> host divisor layout
  always_comb begin
    divHalf = rdWord[15:7];
    clkRd   = {divHalf[7:0], v3Mode ? {1'b0, divHalf[8]} : 2'b00, rdWord[5:0]};
  end

  always_comb begin
    wordRd = rdWord;
    if (rAddr == A_CAPS && disableHighSpeed) wordRd[BIT_HISPEED] = 1'b0;
    if (rAddr == A_STATE && forceCardPresent) wordRd[BIT_CARD_IN] = 1'b1;
  end

  assign laneRd = rdWord >> shamt;

  always_comb begin
    if (kind == OP_HOLD_RD)      hostRdata = {16'h0, (rAddr == A_CMD) ? hold[31:16] : hold[15:0]};
    else if (rSize == SZ_BYTE)   hostRdata = {24'h0, laneRd[7:0]};
    else if (rClk)               hostRdata = {16'h0, clkRd};
    else if (rHalf)              hostRdata = {16'h0, laneRd[15:0]};
    else                         hostRdata = wordRd;
  end

  always_comb begin
    beAddr = {rAddr[ADDR_W-1:2], 2'b00};
    case (kind)
      OP_WORD_WR: beWdata = rData;
      OP_CMD_WR:  beWdata = hold;
      default:    beWdata = rClk ? {rdWord[31:16], divSat, rData[5:0]} : merged;
    endcase
  end

  AST_HOLD_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> hold == '0) else $error("hold not cleared"); // R5
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchReq |=> $stable(rAddr) && $stable(rSize)) else $error("request fields moved"); // R12
endmodule

// File: rtl/lane_bridge_ctrl.sv
module lane_bridge_ctrl
  import lane_bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  opKind_t opNow,
  input  logic    beReady,
  output dpCtl_t  ctl,
  output opKind_t kind,
  output logic    beReq,
  output logic    beWrite,
  output logic    hostReady
);
  typedef enum logic [1:0] {ST_IDLE, ST_BERD, ST_BEWR, ST_DONE} state_t;
  state_t st, stNext;

  always_comb begin
    stNext = st;
    ctl    = '0;
    case (st)
      ST_IDLE: if (hostReq) begin
        ctl.latchReq = 1'b1;
        case (opNow)
          OP_XFER_WR: begin ctl.holdLoWr = 1'b1; stNext = ST_DONE; end
          OP_HOLD_RD: stNext = ST_DONE;
          OP_CMD_WR:  begin ctl.holdHiWr = 1'b1; stNext = ST_BEWR; end
          OP_WORD_WR: stNext = ST_BEWR;
          default:    stNext = ST_BERD;
        endcase
      end
      ST_BERD: if (beReady) begin
        ctl.captureRd = 1'b1;
        stNext = (kind == OP_RMW) ? ST_BEWR : ST_DONE;
      end
      ST_BEWR: if (beReady) stNext = ST_DONE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      kind <= OP_READ;
    end else begin
      st <= stNext;
      if (st == ST_IDLE && hostReq) kind <= opNow;
    end
  end

  assign beReq     = (st == ST_BERD) || (st == ST_BEWR);
  assign beWrite   = (st == ST_BEWR);
  assign hostReady = (st == ST_DONE);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady) else $error("ready longer than one cycle"); // R12
  AST_XFER_NO_BE: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && hostReq && opNow == OP_XFER_WR) |=> (hostReady && !beReq)) else $error("xfer write reached backend"); // R3
  AST_RMW_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (beWrite && !$past(beWrite) && kind == OP_RMW) |-> $past(st) == ST_BERD) else $error("rmw write without read"); // R2
endmodule

// File: rtl/sdhci_lane_bridge.sv
module sdhci_lane_bridge
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostReady,
  input  logic              v3Mode,
  input  logic              disableHighSpeed,
  input  logic              forceCardPresent,
  output logic              beReq,
  output logic              beWrite,
  output logic [ADDR_W-1:0] beAddr,
  output logic [31:0]       beWdata,
  input  logic [31:0]       beRdata,
  input  logic              beReady
);
  dpCtl_t  ctl;
  opKind_t kind, opNow;

  lane_bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .opNow(opNow), .beReady(beReady),
    .ctl(ctl), .kind(kind), .beReq(beReq), .beWrite(beWrite), .hostReady(hostReady)
  );

  lane_bridge_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .kind(kind),
    .hostWrite(hostWrite), .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .v3Mode(v3Mode), .disableHighSpeed(disableHighSpeed), .forceCardPresent(forceCardPresent),
    .beRdata(beRdata), .opNow(opNow), .beAddr(beAddr), .beWdata(beWdata), .hostRdata(hostRdata)
  );

  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beReady) |=> beReq && $stable(beAddr) && $stable(beWrite)) else $error("backend request dropped"); // R12
  AST_DONE_NO_BE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !beReq) else $error("backend busy at completion"); // R12
endmodule

// File: tb/sdhci_lane_bridge_test.sv
`timescale 1ns/1ps
module sdhci_lane_bridge_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 0, hostWrite = 0;
  logic [1:0] hostSize = 0;
  logic [AW-1:0] hostAddr = 0;
  logic [31:0] hostWdata = 0, hostRdata;
  logic hostReady;
  logic v3Mode = 0, disableHighSpeed = 0, forceCardPresent = 0;
  logic beReq, beWrite, beReady = 0;
  logic [AW-1:0] beAddr;
  logic [31:0] beWdata, beRdata = 0;

  int total = 0, bad = 0, cycles = 0;
  int beWrCnt = 0, beRdCnt = 0;
  logic [AW-1:0] lastWrAddr = 0;
  logic [31:0] lastWrData = 0;
  logic [31:0] mem [64];

  always #2.5 clk = ~clk;

  sdhci_lane_bridge #(.ADDR_W(AW)) uut (.*);

  // backend model: one cycle of latency
  always @(posedge clk) begin
    if (beReq && !beReady) begin
      beReady <= 1'b1;
      if (beWrite) begin
        mem[beAddr[7:2]] <= beWdata;
        beWrCnt <= beWrCnt + 1;
        lastWrAddr <= beAddr;
        lastWrData <= beWdata;
      end else begin
        beRdata <= mem[beAddr[7:2]];
        beRdCnt <= beRdCnt + 1;
      end
    end else begin
      beReady <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    int n;
    @(negedge clk);
    hostReq = 1; hostWrite = wr; hostSize = sz; hostAddr = a; hostWdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!hostReady && n < 100);
    rd = hostRdata;
    hostReq = 0;
    @(negedge clk);
    chk("R12 ready pulse", {31'b0, hostReady}, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R12 reset ready", {31'b0, hostReady}, 32'h0);
    chk("R12 reset req", {31'b0, beReq}, 32'h0);
    access(0, 2'd1, 8'h0C, 0, r);
    chk("R5 hold after reset", r, 32'h0);
  endtask

  task automatic t_byte_read();
    logic [31:0] r;
    mem[4] = 32'h4433_2211;
    access(0, 2'd0, 8'h12, 0, r);
    chk("R1 byte lane 2", r, 32'h33);
    access(0, 2'd0, 8'h13, 0, r);
    chk("R1 byte lane 3", r, 32'h44);
  endtask

  task automatic t_rmw();
    logic [31:0] r;
    int w0, r0;
    w0 = beWrCnt; r0 = beRdCnt;
    access(1, 2'd0, 8'h11, 32'hFFFF_FFAB, r);
    chk("R2 byte merge", mem[4], 32'h4433_AB11);
    chk("R2 one read one write", beWrCnt - w0 + 16 * (beRdCnt - r0), 17);
    mem[12] = 32'h1234_5678;
    access(1, 2'd1, 8'h32, 32'h0000_BEEF, r);
    chk("R2 half merge", mem[12], 32'hBEEF_5678);
  endtask

  task automatic t_holding();
    logic [31:0] r;
    int w0, r0;
    w0 = beWrCnt; r0 = beRdCnt;
    access(1, 2'd1, 8'h0C, 32'h0000_1234, r);
    chk("R3 no backend write", beWrCnt - w0, 0);
    chk("R3 no backend read", beRdCnt - r0, 0);
    access(0, 2'd1, 8'h0C, 0, r);
    chk("R5 low half", r, 32'h1234);
    chk("R5 no backend read", beRdCnt - r0, 0);
    access(1, 2'd1, 8'h0E, 32'h0000_5A5A, r);
    chk("R4 single write", beWrCnt - w0, 1);
    chk("R4 address", {24'b0, lastWrAddr}, 32'h0C);
    chk("R4 data", lastWrData, 32'h5A5A_1234);
    access(0, 2'd1, 8'h0E, 0, r);
    chk("R5 high half", r, 32'h5A5A);
  endtask

  task automatic t_clk_write();
    logic [31:0] r;
    v3Mode = 0;
    mem[11] = 32'hDEAD_0000;
    access(1, 2'd1, 8'h2C, 32'h0000_05C7, r);
    chk("R6 v2 divisor", mem[11], 32'hDEAD_0287);
    v3Mode = 1;
    access(1, 2'd1, 8'h2C, 32'h0000_FFC7, r);
    chk("R7 saturate", mem[11], 32'hDEAD_FFC7);
    access(1, 2'd1, 8'h2C, 32'h0000_1045, r);
    chk("R7 upper bits", mem[11], 32'hDEAD_8805);
    v3Mode = 0;
  endtask

  task automatic t_clk_read();
    logic [31:0] r;
    mem[11] = 32'h1234_ABCD;
    v3Mode = 0;
    access(0, 2'd1, 8'h2C, 0, r);
    chk("R8 v2 read", r, 32'h0000_570D);
    v3Mode = 1;
    access(0, 2'd1, 8'h2C, 0, r);
    chk("R8 v3 read", r, 32'h0000_574D);
    v3Mode = 0;
  endtask

  task automatic t_overrides();
    logic [31:0] r;
    mem[16] = 32'hFFFF_FFFF;
    disableHighSpeed = 1;
    access(0, 2'd2, 8'h40, 0, r);
    chk("R9 hs cleared", r, 32'hFFDF_FFFF);
    disableHighSpeed = 0;
    access(0, 2'd2, 8'h40, 0, r);
    chk("R9 hs kept", r, 32'hFFFF_FFFF);
    mem[9] = 32'h0;
    forceCardPresent = 1;
    access(0, 2'd2, 8'h24, 0, r);
    chk("R10 forced", r, 32'h0001_0000);
    forceCardPresent = 0;
    access(0, 2'd2, 8'h24, 0, r);
    chk("R10 not forced", r, 32'h0);
  endtask

  task automatic t_word();
    logic [31:0] r;
    int w0, r0;
    w0 = beWrCnt; r0 = beRdCnt;
    access(1, 2'd2, 8'h20, 32'hCAFE_F00D, r);
    chk("R11 one write", beWrCnt - w0, 1);
    chk("R11 no read", beRdCnt - r0, 0);
    chk("R11 data", mem[8], 32'hCAFE_F00D);
    access(0, 2'd2, 8'h20, 0, r);
    chk("R11 word read", r, 32'hCAFE_F00D);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_byte_read();
    t_rmw();
    t_holding();
    t_clk_write();
    t_clk_read();
    t_overrides();
    t_word();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule